// File: doc/BRIEF.md
# EMG Time-Domain Feature Extractor

This block condenses a window of samples from two sensor channels into a small set of time-domain features. The first channel carries signed electromyographic samples. From it the block reports four features: the window average, the number of slope reversals, the total travelled amplitude (waveform length) and the number of sign changes. The second channel carries a signed force or moment reading. From it the block reports the largest value, the smallest value and the average over the same window.

A window opens with a single-cycle start strobe. It closes after a fixed, power-of-two number of accepted samples. A sample counts only when its valid flag is high, so idle cycles may sit between samples. One cycle after the final sample is accepted, all seven results appear together with a one-cycle done pulse. The results then stay unchanged until the next done pulse. A programmable dead-band keeps small noise steps from being counted as sign changes or slope reversals. Accumulators are sized for a full window of extreme samples.

Top module: `emg_feature_window`

## Requirements
- R1: A window holds exactly 2^LOG2_WIN samples accepted with in_valid high. A sample presented in the same cycle as win_start is the first sample of the window. Cycles with in_valid low are skipped.
- R2: done is high for exactly one cycle, in the cycle after the final sample of a window is accepted. It is low at all other times. All result outputs stay unchanged in every cycle where done is low.
- R3: emg_mean equals the sum of the window's EMG samples divided by 2^LOG2_WIN, rounded toward minus infinity.
- R4: emg_wl equals the sum, over every pair of consecutive samples in the window, of the absolute value of their difference.
- R5: emg_zc counts consecutive pairs in which one sample is negative and the other is zero or positive, and whose absolute difference is at least DEADBAND.
- R6: emg_ssc counts interior samples x[n] where one neighbour step is at least +DEADBAND and the other is at most -DEADBAND. The steps are d1 = x[n]-x[n-1] and d2 = x[n+1]-x[n], and the count applies when d1 >= DEADBAND with d2 <= -DEADBAND, or d1 <= -DEADBAND with d2 >= DEADBAND.
- R7: frc_max and frc_min equal the signed largest and smallest force samples of the window.
- R8: frc_mean equals the sum of the window's force samples divided by 2^LOG2_WIN, rounded toward minus infinity.
- R9: Samples accepted before the first win_start, or after a window has completed and before the next win_start, have no effect and produce no done pulse. A win_start in the middle of a window discards the partial window and begins a new one.
- R10: While rst_n is low, and after its release until the first done pulse, done and every result output read zero.
- R11: A full window of full-scale samples gives exact results without overflow. An example is EMG samples alternating between the most positive and most negative codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_start | input | 1 | Single-cycle strobe that opens a window |
| in_valid | input | 1 | Sample qualifier for both channels |
| emg_in | input | SAMPLE_W | Signed EMG sample |
| frc_in | input | FORCE_W | Signed force or moment sample |
| done | output | 1 | One-cycle pulse when results update |
| emg_mean | output | SAMPLE_W | Signed EMG window average |
| emg_ssc | output | LOG2_WIN+1 | Slope-reversal count |
| emg_wl | output | SAMPLE_W+LOG2_WIN+1 | Waveform length |
| emg_zc | output | LOG2_WIN+1 | Sign-change count |
| frc_max | output | FORCE_W | Signed force maximum |
| frc_min | output | FORCE_W | Signed force minimum |
| frc_mean | output | FORCE_W | Signed force window average |

## Verification
The properties assume that win_start and in_valid are always known and that LOG2_WIN is at least 2. This guarantees that each window spans at least four clock cycles, so done can never be high in two back-to-back cycles. The range and ordering checks on the force results rely on inputs staying within their signed width, which holds by construction of the ports. The stimulus drives every input half a period away from the active edge. It keeps samples in range: table patterns stay within about ±2100 counts, and the full-scale directed windows use the exact extreme codes.

// File: rtl/emg_feat_pkg.sv
package emg_feat_pkg;

  // Per-sample window control shared by the datapaths.
  typedef struct packed {
    logic take;   // sample accepted this cycle
    logic first;  // accepted sample opens the window
    logic last;   // accepted sample closes the window
  } win_ctl_t;

endpackage

// File: rtl/emg_win_ctrl.sv
module emg_win_ctrl
  import emg_feat_pkg::*;
#(
  parameter int LOG2_WIN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     win_start,
  input  logic     in_valid,
  output win_ctl_t ctl,
  output logic     done
);
  localparam int CNT_W = LOG2_WIN + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'((1 << LOG2_WIN) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n, base;
  logic             armed_q, armed_n;
  logic             done_q;

  always_comb begin
    base      = win_start ? '0 : cnt_q;
    ctl.take  = in_valid & (win_start | armed_q);
    ctl.first = ctl.take & (base == '0);
    ctl.last  = ctl.take & (base == LAST_IDX);
    cnt_n     = cnt_q;
    armed_n   = armed_q;
    if (win_start) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end
    if (ctl.take) cnt_n = base + 1'b1;
    if (ctl.last) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      done_q  <= ctl.last;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/emg_emg_path.sv
module emg_emg_path
  import emg_feat_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LOG2_WIN = 4,
  parameter int DEADBAND = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  win_ctl_t                       ctl,
  input  logic signed [SAMPLE_W-1:0]     x,
  output logic signed [SAMPLE_W-1:0]     o_mean,
  output logic [SAMPLE_W+LOG2_WIN:0]     o_wl,
  output logic [LOG2_WIN:0]              o_zc,
  output logic [LOG2_WIN:0]              o_ssc
);
  localparam int DW    = SAMPLE_W + 1;
  localparam int SUM_W = SAMPLE_W + LOG2_WIN;
  localparam int WL_W  = DW + LOG2_WIN;
  localparam int CNT_W = LOG2_WIN + 1;
  localparam logic [DW-1:0]        DB_U  = DW'(DEADBAND);
  localparam logic signed [DW-1:0] DB_P  = DW'(DEADBAND);
  localparam logic signed [DW-1:0] DB_N  = -DW'(DEADBAND);

  logic signed [SUM_W-1:0]    sum_q, sum_n, sum_sh;
  logic [WL_W-1:0]            wl_q, wl_n;
  logic [CNT_W-1:0]           zc_q, zc_n, ssc_q, ssc_n;
  logic signed [SAMPLE_W-1:0] prev_q;
  logic signed [DW-1:0]       pdiff_q, diff;
  logic                       pdv_q, pdv_n;
  logic [DW-1:0]              absd;
  logic                       zc_hit, rev_hit;

  always_comb begin
    diff    = $signed({x[SAMPLE_W-1], x}) - $signed({prev_q[SAMPLE_W-1], prev_q});
    absd    = diff[DW-1] ? DW'(-diff) : DW'(diff);
    zc_hit  = (x[SAMPLE_W-1] != prev_q[SAMPLE_W-1]) && (absd >= DB_U);
    rev_hit = ((pdiff_q >= DB_P) && (diff <= DB_N)) ||
              ((pdiff_q <= DB_N) && (diff >= DB_P));
    if (ctl.first) begin
      sum_n = {{LOG2_WIN{x[SAMPLE_W-1]}}, x};
      wl_n  = '0;
      zc_n  = '0;
      ssc_n = '0;
      pdv_n = 1'b0;
    end else begin
      sum_n = sum_q + {{LOG2_WIN{x[SAMPLE_W-1]}}, x};
      wl_n  = wl_q + WL_W'(absd);
      zc_n  = zc_q + CNT_W'(zc_hit);
      ssc_n = ssc_q + CNT_W'(pdv_q & rev_hit);
      pdv_n = 1'b1;
    end
    sum_sh = sum_n >>> LOG2_WIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      wl_q    <= '0;
      zc_q    <= '0;
      ssc_q   <= '0;
      prev_q  <= '0;
      pdiff_q <= '0;
      pdv_q   <= 1'b0;
    end else if (ctl.take) begin
      sum_q   <= sum_n;
      wl_q    <= wl_n;
      zc_q    <= zc_n;
      ssc_q   <= ssc_n;
      prev_q  <= x;
      pdiff_q <= diff;
      pdv_q   <= pdv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_mean <= '0;
      o_wl   <= '0;
      o_zc   <= '0;
      o_ssc  <= '0;
    end else if (ctl.last) begin
      o_mean <= sum_sh[SAMPLE_W-1:0];
      o_wl   <= wl_n;
      o_zc   <= zc_n;
      o_ssc  <= ssc_n;
    end
  end
endmodule

// File: rtl/emg_force_path.sv
module emg_force_path
  import emg_feat_pkg::*;
#(
  parameter int FORCE_W  = 12,
  parameter int LOG2_WIN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  win_ctl_t                   ctl,
  input  logic signed [FORCE_W-1:0]  f,
  output logic signed [FORCE_W-1:0]  o_max,
  output logic signed [FORCE_W-1:0]  o_min,
  output logic signed [FORCE_W-1:0]  o_mean
);
  localparam int SUM_W = FORCE_W + LOG2_WIN;

  logic signed [FORCE_W-1:0] max_q, max_n, min_q, min_n;
  logic signed [SUM_W-1:0]   sum_q, sum_n, sum_sh;

  always_comb begin
    if (ctl.first) begin
      max_n = f;
      min_n = f;
      sum_n = {{LOG2_WIN{f[FORCE_W-1]}}, f};
    end else begin
      max_n = (f > max_q) ? f : max_q;
      min_n = (f < min_q) ? f : min_q;
      sum_n = sum_q + {{LOG2_WIN{f[FORCE_W-1]}}, f};
    end
    sum_sh = sum_n >>> LOG2_WIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      min_q <= '0;
      sum_q <= '0;
    end else if (ctl.take) begin
      max_q <= max_n;
      min_q <= min_n;
      sum_q <= sum_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_max  <= '0;
      o_min  <= '0;
      o_mean <= '0;
    end else if (ctl.last) begin
      o_max  <= max_n;
      o_min  <= min_n;
      o_mean <= sum_sh[FORCE_W-1:0];
    end
  end
endmodule

// File: rtl/emg_feature_window.sv
module emg_feature_window
  import emg_feat_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FORCE_W  = 12,
  parameter int LOG2_WIN = 4,
  parameter int DEADBAND = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              win_start,
  input  logic                              in_valid,
  input  logic signed [SAMPLE_W-1:0]        emg_in,
  input  logic signed [FORCE_W-1:0]         frc_in,
  output logic                              done,
  output logic signed [SAMPLE_W-1:0]        emg_mean,
  output logic [LOG2_WIN:0]                 emg_ssc,
  output logic [SAMPLE_W+LOG2_WIN:0]        emg_wl,
  output logic [LOG2_WIN:0]                 emg_zc,
  output logic signed [FORCE_W-1:0]         frc_max,
  output logic signed [FORCE_W-1:0]         frc_min,
  output logic signed [FORCE_W-1:0]         frc_mean
);
  win_ctl_t ctl;

  emg_win_ctrl #(.LOG2_WIN(LOG2_WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .in_valid(in_valid),
    .ctl(ctl), .done(done)
  );

  emg_emg_path #(.SAMPLE_W(SAMPLE_W), .LOG2_WIN(LOG2_WIN), .DEADBAND(DEADBAND)) u_emg (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .x(emg_in),
    .o_mean(emg_mean), .o_wl(emg_wl), .o_zc(emg_zc), .o_ssc(emg_ssc)
  );

  emg_force_path #(.FORCE_W(FORCE_W), .LOG2_WIN(LOG2_WIN)) u_frc (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .f(frc_in),
    .o_max(frc_max), .o_min(frc_min), .o_mean(frc_mean)
  );
endmodule

// File: rtl/emg_feat_chk.sv
module emg_feat_chk #(
  parameter int SAMPLE_W = 12,
  parameter int FORCE_W  = 12,
  parameter int LOG2_WIN = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       done,
  input logic signed [SAMPLE_W-1:0] emg_mean,
  input logic [LOG2_WIN:0]          emg_ssc,
  input logic [SAMPLE_W+LOG2_WIN:0] emg_wl,
  input logic [LOG2_WIN:0]          emg_zc,
  input logic signed [FORCE_W-1:0]  frc_max,
  input logic signed [FORCE_W-1:0]  frc_min,
  input logic signed [FORCE_W-1:0]  frc_mean
);
  localparam logic [LOG2_WIN:0] ZC_MAX  = (LOG2_WIN+1)'((1 << LOG2_WIN) - 1);
  localparam logic [LOG2_WIN:0] SSC_MAX = (LOG2_WIN+1)'((1 << LOG2_WIN) - 2);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(emg_mean) && $stable(emg_wl) && $stable(emg_zc) &&
               $stable(emg_ssc) && $stable(frc_max) && $stable(frc_min) &&
               $stable(frc_mean)));

  a_r1_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));

  a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
    frc_min <= frc_max);

  a_r8_mean_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_mean >= frc_min) && (frc_mean <= frc_max));

  a_r5_zc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    emg_zc <= ZC_MAX);

  a_r6_ssc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    emg_ssc <= SSC_MAX);
endmodule

bind emg_feature_window emg_feat_chk #(
  .SAMPLE_W(SAMPLE_W), .FORCE_W(FORCE_W), .LOG2_WIN(LOG2_WIN)
) u_feat_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .done(done),
  .emg_mean(emg_mean), .emg_ssc(emg_ssc), .emg_wl(emg_wl), .emg_zc(emg_zc),
  .frc_max(frc_max), .frc_min(frc_min), .frc_mean(frc_mean)
);

// File: tb/test_emg_feature_window.sv
`timescale 1ns/1ps
module test_emg_feature_window;
  localparam int SW = 12, FW = 12, LW = 4, DB = 4;
  localparam int WIN = 1 << LW;
  localparam int NPAT = 6;
  // columns: emg dc, emg amplitude, half period, force dc, force step, idle gap
  localparam int PAT [NPAT][6] = '{
    '{   0,    2, 1,    0,  10, 0},
    '{  50,  300, 3,  200,  40, 1},
    '{-400,  700, 2, -300,  90, 0},
    '{ 500,  100, 4,   50,   7, 2},
    '{   0, 2000, 1,    0, 100, 0},
    '{ -20,    3, 2, -900,   1, 1}
  };

  logic clk = 1'b0;
  logic rst_n, win_start, in_valid, done;
  logic signed [SW-1:0] emg_in, emg_mean;
  logic signed [FW-1:0] frc_in, frc_max, frc_min, frc_mean;
  logic [LW:0] emg_ssc, emg_zc;
  logic [SW+LW:0] emg_wl;

  int total = 0, bad = 0, early = 0;
  int ge [WIN];
  int gf [WIN];
  int x_mean, x_wl, x_zc, x_ssc, x_max, x_min, x_fmean;

  always #5 clk = ~clk;

  emg_feature_window #(.SAMPLE_W(SW), .FORCE_W(FW), .LOG2_WIN(LW), .DEADBAND(DB)) i_emg_feature_window (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .in_valid(in_valid),
    .emg_in(emg_in), .frc_in(frc_in), .done(done), .emg_mean(emg_mean),
    .emg_ssc(emg_ssc), .emg_wl(emg_wl), .emg_zc(emg_zc),
    .frc_max(frc_max), .frc_min(frc_min), .frc_mean(frc_mean)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fdiv(int s);
    return (s >= 0) ? s / WIN : -((-s + WIN - 1) / WIN);
  endfunction

  task automatic model();
    int se = 0, sf = 0;
    x_wl = 0; x_zc = 0; x_ssc = 0; x_max = gf[0]; x_min = gf[0];
    for (int i = 0; i < WIN; i++) begin
      se += ge[i]; sf += gf[i];
      if (gf[i] > x_max) x_max = gf[i];
      if (gf[i] < x_min) x_min = gf[i];
      if (i > 0) begin
        int d = ge[i] - ge[i-1];
        int a = (d < 0) ? -d : d;
        x_wl += a;
        if (((ge[i] < 0) != (ge[i-1] < 0)) && a >= DB) x_zc++;
      end
      if (i > 0 && i < WIN-1) begin
        int d1 = ge[i] - ge[i-1];
        int d2 = ge[i+1] - ge[i];
        if ((d1 >= DB && d2 <= -DB) || (d1 <= -DB && d2 >= DB)) x_ssc++;
      end
    end
    x_mean = fdiv(se); x_fmean = fdiv(sf);
  endtask

  task automatic load_pat(int p);
    for (int i = 0; i < WIN; i++) begin
      ge[i] = PAT[p][0] + ((((i / PAT[p][2]) % 2) != 0) ? -PAT[p][1] : PAT[p][1]);
      gf[i] = PAT[p][3] + PAT[p][4] * ((i * 7) % WIN) - PAT[p][4] * 8;
    end
  endtask

  // Drives one window; returns at the negedge after the last sample's edge.
  task automatic run_window(int n, int gap, bit start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) early++;
      win_start = (i == 0) && start;
      in_valid = 1'b1;
      emg_in = SW'(ge[i]);
      frc_in = FW'(gf[i]);
      if (i < n - 1)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (done) early++;
          win_start = 1'b0; in_valid = 1'b0;
        end
    end
    @(negedge clk);
    win_start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic check_all(string tag);
    model();
    chk({tag, " R2 done pulse"}, int'(done), 1);
    chk({tag, " R3 emg mean"}, int'(emg_mean), x_mean);
    chk({tag, " R4 waveform length"}, int'(emg_wl), x_wl);
    chk({tag, " R5 zero crossings"}, int'(emg_zc), x_zc);
    chk({tag, " R6 slope changes"}, int'(emg_ssc), x_ssc);
    chk({tag, " R7 force max"}, int'(frc_max), x_max);
    chk({tag, " R7 force min"}, int'(frc_min), x_min);
    chk({tag, " R8 force mean"}, int'(frc_mean), x_fmean);
    @(negedge clk);
    chk({tag, " R2 done drops"}, int'(done), 0);
    chk({tag, " R2 result held"}, int'(emg_wl), x_wl);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; win_start = 1'b0; in_valid = 1'b0; emg_in = '0; frc_in = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done in reset", int'(done), 0);
    chk("R10 wl in reset", int'(emg_wl), 0);
    chk("R10 force max in reset", int'(frc_max), 0);
    rst_n = 1'b1;

    // R9: samples before any window start are ignored
    load_pat(2);
    run_window(WIN + 4, 0, 1'b0);
    chk("R9 no done before start", early + int'(done), 0);
    chk("R9 mean untouched", int'(emg_mean), 0);
    chk("R10 ssc after reset", int'(emg_ssc), 0);

    // R1..R8: table of patterns
    for (int p = 0; p < NPAT; p++) begin
      load_pat(p);
      early = 0;
      run_window(WIN, PAT[p][5], 1'b1);
      check_all($sformatf("pat%0d R1", p));
      chk("R2 no early done", early, 0);
    end

    // R9: samples after completion ignored, results held
    load_pat(1);
    early = 0;
    run_window(WIN, 0, 1'b0);
    chk("R9 no done after window", early + int'(done), 0);
    load_pat(NPAT - 1);
    model();
    chk("R9 results held", int'(frc_min), x_min);

    // R9: restart mid-window discards partial data
    load_pat(4);
    run_window(5, 0, 1'b1);
    load_pat(3);
    early = 0;
    run_window(WIN, 0, 1'b1);
    check_all("restart R9");
    chk("R9 restart no early done", early, 0);

    // R11: full-scale alternating EMG, force at positive limit
    for (int i = 0; i < WIN; i++) begin
      ge[i] = (i % 2 == 0) ? 2047 : -2048;
      gf[i] = 2047;
    end
    run_window(WIN, 0, 1'b1);
    check_all("fullscale R11");
    chk("R11 wl exact", int'(emg_wl), 15 * 4095);

    // R11: all most-negative samples
    for (int i = 0; i < WIN; i++) begin
      ge[i] = -2048;
      gf[i] = -2048;
    end
    run_window(WIN, 1, 1'b1);
    check_all("negscale R11");
    chk("R11 force mean floor", int'(frc_mean), -2048);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule